// File: doc/BRIEF.md
# Memory Operand Segment Repeater with Local Word Cache

This block joins two segments of a memory-operand forwarding interconnect inside a large out-of-order execution array. It passes traffic in both directions and adds one clock on each. Store broadcasts travel toward later stations. Each broadcast carries an address, a data word and a time-tag. The block registers each broadcast onto the next segment unchanged.

Every broadcast that passes through is also recorded in a small, fully associative local cache. Each entry holds one word, keyed by address. Load requests travel backward from later stations, and each one is looked up in this cache.

- **Hit:** the block answers the request itself on a reply lane of the forward bus, one clock later. The reply carries the cached word, the time-tag of the store that produced it, and the requester's time-tag. The request is filtered and goes no further back.
- **Miss:** the request is registered onto the backward segment, toward earlier stations, one clock later.

When a broadcast and a request for the same address arrive in the same cycle, the broadcast is taken first. The request therefore sees the new word. Free entries are filled before any entry is replaced. Once the cache is full, a round-robin pointer chooses which entry to replace.

Top module: `mfu_l0_repeater`

## Requirements
- R1: A store broadcast accepted in cycle t appears on `fwd_out_*` in cycle t+1 with the same address, data and time-tag; with no broadcast in cycle t, `fwd_out_vld` is 0 in cycle t+1.
- R2: A request in cycle t whose address is not cached appears on `bwd_out_*` in cycle t+1 with the same address and time-tag, and `rsp_out_vld` is 0 in cycle t+1.
- R3: A request in cycle t whose address is cached produces `rsp_out_*` in cycle t+1, carrying the address, the cached data, the cached store time-tag and the request time-tag; `bwd_out_vld` is 0 in cycle t+1. With no request in cycle t, neither `rsp_out_vld` nor `bwd_out_vld` is 1 in cycle t+1.
- R4: A broadcast to an address that is already cached overwrites that entry in place. Later hits return the newest data and time-tag, and no other entry is consumed or replaced.
- R5: A broadcast to a new address fills the lowest-index free entry. When all ENTRIES entries are valid, the entry at a round-robin pointer is replaced. The pointer starts at index 0 after reset, advances by one per replacement and wraps to 0 after ENTRIES-1. With 32 entries, after 33 distinct addresses the first one misses and the second and 33rd hit.
- R6: When a broadcast and a request name the same address in one cycle, the reply in the next cycle carries the broadcast's data and time-tag.
- R7: While `rst` is high at a clock edge, all three output valids are 0 after that edge. After reset the cache is empty, so every request misses until a broadcast fills it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fwd_in_vld | input | 1 | Store broadcast valid from the earlier segment |
| fwd_in_addr | input | AW | Broadcast word address |
| fwd_in_data | input | DW | Broadcast data word |
| fwd_in_ttag | input | TW | Broadcast time-tag |
| bwd_in_vld | input | 1 | Load request valid from the later segment |
| bwd_in_addr | input | AW | Requested word address |
| bwd_in_ttag | input | TW | Requester time-tag |
| fwd_out_vld | output | 1 | Registered broadcast valid to the later segment |
| fwd_out_addr | output | AW | Registered broadcast address |
| fwd_out_data | output | DW | Registered broadcast data |
| fwd_out_ttag | output | TW | Registered broadcast time-tag |
| rsp_out_vld | output | 1 | Local reply valid (forward reply lane) |
| rsp_out_addr | output | AW | Reply address |
| rsp_out_data | output | DW | Reply data word |
| rsp_out_stag | output | TW | Time-tag of the store that produced the word |
| rsp_out_rtag | output | TW | Time-tag of the request being answered |
| bwd_out_vld | output | 1 | Propagated request valid to the earlier segment |
| bwd_out_addr | output | AW | Propagated request address |
| bwd_out_ttag | output | TW | Propagated request time-tag |

## Verification
Replacement is the hardest case to reach from the ports, because an entry is only ever evicted after every slot is full. The stimulus resets the block, streams 32 distinct addresses to fill it, and rewrites one resident address. It then checks that this rewrite does not move the victim pointer. Next it inserts a 33rd and a 34th address, probing with requests after each insertion to see which entries survive. The same-cycle case, with a broadcast and a request for one address, is driven both on a fresh address and on an already cached one, so the bypass is visible in the reply data.

// File: rtl/mfu_pkg.sv
package mfu_pkg;
  // How a broadcast lands in the local cache.
  typedef enum logic [1:0] {
    WR_NONE   = 2'd0,
    WR_UPDATE = 2'd1,
    WR_FILL   = 2'd2,
    WR_EVICT  = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/mfu_rr_victim.sv
module mfu_rr_victim #(
  parameter int ENTRIES = 32,
  parameter int IW      = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [IW-1:0] ptr
);
  localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

  logic [IW-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (rst)      ptr_q <= '0;
    else if (adv) ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr = ptr_q;

  // R5: the pointer advances by exactly one slot per replacement, wrapping at the end
  assert_rr_step_R5: assert property (@(posedge clk) disable iff (rst)
    adv |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));

  // R5: the pointer is held when nothing is replaced
  assert_rr_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr_q));
endmodule

// File: rtl/mfu_l0_tags.sv
module mfu_l0_tags
  import mfu_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int AW      = 32,
  parameter int IW      = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] lk_addr,
  output logic          lk_hit,
  output logic [IW-1:0] lk_idx,
  output logic [IW-1:0] wr_idx,
  output wr_kind_e      wr_kind
);
  logic [ENTRIES-1:0] vld_q;
  logic [AW-1:0]      addr_q [ENTRIES];
  logic [ENTRIES-1:0] wr_match;
  logic [ENTRIES-1:0] lk_match;
  logic [IW-1:0]      upd_idx, free_idx, rr_ptr;
  logic               all_full;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign wr_match[i] = vld_q[i] && (addr_q[i] == wr_addr);
    assign lk_match[i] = vld_q[i] && (addr_q[i] == lk_addr);

    always_ff @(posedge clk) begin
      if (rst)                               vld_q[i] <= 1'b0;
      else if (wr_en && wr_idx == IW'(i))    vld_q[i] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IW'(i)) addr_q[i] <= wr_addr;
    end
  end

  assign all_full = &vld_q;

  // Priority encoders: lowest index wins.
  always_comb begin
    upd_idx  = '0;
    free_idx = '0;
    lk_idx   = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (wr_match[i]) upd_idx  = IW'(i);
      if (!vld_q[i])   free_idx = IW'(i);
      if (lk_match[i]) lk_idx   = IW'(i);
    end
  end

  assign lk_hit = |lk_match;

  always_comb begin
    if (!wr_en) begin
      wr_kind = WR_NONE;
      wr_idx  = upd_idx;
    end else if (|wr_match) begin
      wr_kind = WR_UPDATE;
      wr_idx  = upd_idx;
    end else if (!all_full) begin
      wr_kind = WR_FILL;
      wr_idx  = free_idx;
    end else begin
      wr_kind = WR_EVICT;
      wr_idx  = rr_ptr;
    end
  end

  mfu_rr_victim #(.ENTRIES(ENTRIES), .IW(IW)) u_victim (
    .clk (clk),
    .rst (rst),
    .adv (wr_kind == WR_EVICT),
    .ptr (rr_ptr)
  );

  // R4: an address is never held by two entries
  assert_unique_addr_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_match));

  // R5: a fill only ever turns exactly one more entry valid
  assert_fill_one_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_kind == WR_FILL) |=> ($countones(vld_q) == $countones($past(vld_q)) + 1));

  // R4: an in-place update leaves occupancy unchanged
  assert_update_keeps_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_kind == WR_UPDATE) |=> $stable(vld_q));
endmodule

// File: rtl/mfu_l0_data.sv
module mfu_l0_data #(
  parameter int ENTRIES = 32,
  parameter int DW      = 32,
  parameter int TW      = 8,
  parameter int IW      = 5
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [TW-1:0] wr_stag,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  output logic [TW-1:0] rd_stag
);
  localparam int EW = DW + TW;

  // Single write port, asynchronous read: maps onto distributed RAM.
  logic [EW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= {wr_stag, wr_data};
  end

  assign {rd_stag, rd_data} = mem[rd_idx];
endmodule

// File: rtl/mfu_l0_repeater.sv
module mfu_l0_repeater
  import mfu_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int TW      = 8,
  parameter int ENTRIES = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fwd_in_vld,
  input  logic [AW-1:0] fwd_in_addr,
  input  logic [DW-1:0] fwd_in_data,
  input  logic [TW-1:0] fwd_in_ttag,
  input  logic          bwd_in_vld,
  input  logic [AW-1:0] bwd_in_addr,
  input  logic [TW-1:0] bwd_in_ttag,
  output logic          fwd_out_vld,
  output logic [AW-1:0] fwd_out_addr,
  output logic [DW-1:0] fwd_out_data,
  output logic [TW-1:0] fwd_out_ttag,
  output logic          rsp_out_vld,
  output logic [AW-1:0] rsp_out_addr,
  output logic [DW-1:0] rsp_out_data,
  output logic [TW-1:0] rsp_out_stag,
  output logic [TW-1:0] rsp_out_rtag,
  output logic          bwd_out_vld,
  output logic [AW-1:0] bwd_out_addr,
  output logic [TW-1:0] bwd_out_ttag
);
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic          lk_hit;
  logic [IW-1:0] lk_idx, wr_idx;
  wr_kind_e      wr_kind;
  logic [DW-1:0] mem_data;
  logic [TW-1:0] mem_stag;
  logic          same_addr, hit;
  logic [DW-1:0] hit_data;
  logic [TW-1:0] hit_stag;

  mfu_l0_tags #(.ENTRIES(ENTRIES), .AW(AW), .IW(IW)) u_tags (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (fwd_in_vld),
    .wr_addr (fwd_in_addr),
    .lk_addr (bwd_in_addr),
    .lk_hit  (lk_hit),
    .lk_idx  (lk_idx),
    .wr_idx  (wr_idx),
    .wr_kind (wr_kind)
  );

  mfu_l0_data #(.ENTRIES(ENTRIES), .DW(DW), .TW(TW), .IW(IW)) u_data (
    .clk     (clk),
    .wr_en   (fwd_in_vld),
    .wr_idx  (wr_idx),
    .wr_data (fwd_in_data),
    .wr_stag (fwd_in_ttag),
    .rd_idx  (lk_idx),
    .rd_data (mem_data),
    .rd_stag (mem_stag)
  );

  // Same-cycle broadcast wins: the request sees the word being written.
  assign same_addr = fwd_in_vld && (fwd_in_addr == bwd_in_addr);
  assign hit       = same_addr || lk_hit;
  assign hit_data  = same_addr ? fwd_in_data : mem_data;
  assign hit_stag  = same_addr ? fwd_in_ttag : mem_stag;

  // Valids: reset registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      fwd_out_vld <= 1'b0;
      rsp_out_vld <= 1'b0;
      bwd_out_vld <= 1'b0;
    end else begin
      fwd_out_vld <= fwd_in_vld;
      rsp_out_vld <= bwd_in_vld && hit;
      bwd_out_vld <= bwd_in_vld && !hit;
    end
  end

  // Payloads: no reset, loaded on their valid.
  always_ff @(posedge clk) begin
    if (fwd_in_vld) begin
      fwd_out_addr <= fwd_in_addr;
      fwd_out_data <= fwd_in_data;
      fwd_out_ttag <= fwd_in_ttag;
    end
    if (bwd_in_vld && hit) begin
      rsp_out_addr <= bwd_in_addr;
      rsp_out_data <= hit_data;
      rsp_out_stag <= hit_stag;
      rsp_out_rtag <= bwd_in_ttag;
    end
    if (bwd_in_vld && !hit) begin
      bwd_out_addr <= bwd_in_addr;
      bwd_out_ttag <= bwd_in_ttag;
    end
  end

  // R1: a broadcast emerges one clock later with its fields intact
  assert_fwd_pass_R1: assert property (@(posedge clk) disable iff (rst)
    fwd_in_vld |=> (fwd_out_vld && fwd_out_addr == $past(fwd_in_addr)
                    && fwd_out_data == $past(fwd_in_data)
                    && fwd_out_ttag == $past(fwd_in_ttag)));

  // R1: no broadcast in, none out
  assert_fwd_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !fwd_in_vld |=> !fwd_out_vld);

  // R3: each request is either answered or passed back, never both
  assert_one_outcome_R3: assert property (@(posedge clk) disable iff (rst)
    bwd_in_vld |=> (rsp_out_vld != bwd_out_vld));

  // R3: without a request there is no reply and no backward traffic
  assert_no_spurious_R3: assert property (@(posedge clk) disable iff (rst)
    !bwd_in_vld |=> (!rsp_out_vld && !bwd_out_vld));

  // R2: a propagated request carries its own address and tag
  assert_bwd_fields_R2: assert property (@(posedge clk) disable iff (rst)
    bwd_out_vld |-> (bwd_out_addr == $past(bwd_in_addr)
                     && bwd_out_ttag == $past(bwd_in_ttag)));

  // R6: same-cycle broadcast and request: the reply holds the broadcast word
  assert_bypass_R6: assert property (@(posedge clk) disable iff (rst)
    (fwd_in_vld && bwd_in_vld && fwd_in_addr == bwd_in_addr)
      |=> (rsp_out_vld && rsp_out_data == $past(fwd_in_data)
           && rsp_out_stag == $past(fwd_in_ttag)));
endmodule

// File: tb/sim_mfu_l0_repeater.sv
`timescale 1ns/1ps
module sim_mfu_l0_repeater;
  localparam int AW = 32, DW = 32, TW = 8, N = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          fwd_in_vld = 1'b0;
  logic [AW-1:0] fwd_in_addr = '0;
  logic [DW-1:0] fwd_in_data = '0;
  logic [TW-1:0] fwd_in_ttag = '0;
  logic          bwd_in_vld = 1'b0;
  logic [AW-1:0] bwd_in_addr = '0;
  logic [TW-1:0] bwd_in_ttag = '0;
  logic          fwd_out_vld, rsp_out_vld, bwd_out_vld;
  logic [AW-1:0] fwd_out_addr, rsp_out_addr, bwd_out_addr;
  logic [DW-1:0] fwd_out_data, rsp_out_data;
  logic [TW-1:0] fwd_out_ttag, rsp_out_stag, rsp_out_rtag, bwd_out_ttag;

  always #2 clk = ~clk; // 250 MHz

  mfu_l0_repeater #(.AW(AW), .DW(DW), .TW(TW), .ENTRIES(N)) u0 (.*);

  typedef struct {
    logic          fv; logic [AW-1:0] fa; logic [DW-1:0] fd; logic [TW-1:0] ft;
    logic          rv; logic [AW-1:0] ra; logic [DW-1:0] rd; logic [TW-1:0] rs; logic [TW-1:0] rr;
    logic          bv; logic [AW-1:0] ba; logic [TW-1:0] bt;
  } exp_t;

  exp_t  exp_q [$];
  string req_q [$];
  int    n_vec = 0, n_bad = 0;

  // Reference cache built from the requirements.
  logic          m_vld  [N];
  logic [AW-1:0] m_addr [N];
  logic [DW-1:0] m_data [N];
  logic [TW-1:0] m_stag [N];
  int            m_ptr;

  function automatic void model_clear();
    for (int i = 0; i < N; i++) m_vld[i] = 1'b0;
    m_ptr = 0;
  endfunction

  function automatic int model_find(logic [AW-1:0] a);
    for (int i = 0; i < N; i++) if (m_vld[i] && m_addr[i] == a) return i;
    return -1;
  endfunction

  function automatic void model_write(logic [AW-1:0] a, logic [DW-1:0] d, logic [TW-1:0] t);
    int k;
    k = model_find(a);
    if (k < 0) begin
      for (int i = N - 1; i >= 0; i--) if (!m_vld[i]) k = i;
      if (k < 0) begin k = m_ptr; m_ptr = (m_ptr + 1) % N; end
    end
    m_vld[k] = 1'b1; m_addr[k] = a; m_data[k] = d; m_stag[k] = t;
  endfunction

  task automatic step(input logic fv, input logic [AW-1:0] fa, input logic [DW-1:0] fd,
                      input logic [TW-1:0] ft, input logic bv, input logic [AW-1:0] ba,
                      input logic [TW-1:0] bt, input string req);
    exp_t e;
    int   k;
    @(negedge clk);
    fwd_in_vld = fv; fwd_in_addr = fa; fwd_in_data = fd; fwd_in_ttag = ft;
    bwd_in_vld = bv; bwd_in_addr = ba; bwd_in_ttag = bt;
    e.fv = fv; e.fa = fa; e.fd = fd; e.ft = ft;
    e.rv = 1'b0; e.ra = '0; e.rd = '0; e.rs = '0; e.rr = '0;
    e.bv = 1'b0; e.ba = '0; e.bt = '0;
    if (fv) model_write(fa, fd, ft);
    if (bv) begin
      k = model_find(ba);
      if (k >= 0) begin
        e.rv = 1'b1; e.ra = ba; e.rd = m_data[k]; e.rs = m_stag[k]; e.rr = bt;
      end else begin
        e.bv = 1'b1; e.ba = ba; e.bt = bt;
      end
    end
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  task automatic st(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [TW-1:0] t, input string req);
    step(1'b1, a, d, t, 1'b0, '0, '0, req);
  endtask

  task automatic ld(input logic [AW-1:0] a, input logic [TW-1:0] t, input string req);
    step(1'b0, '0, '0, '0, 1'b1, a, t, req);
  endtask

  task automatic idle();
    step(1'b0, '0, '0, '0, 1'b0, '0, '0, "R1/R3 idle");
  endtask

  // Monitor: pops one expectation per cycle and compares the three lanes.
  always @(posedge clk) begin
    exp_t  e;
    string r;
    #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      r = req_q.pop_front();
      n_vec++;
      if (fwd_out_vld !== e.fv || (e.fv && {fwd_out_addr, fwd_out_data, fwd_out_ttag} !== {e.fa, e.fd, e.ft})) begin
        n_bad++;
        $display("FAIL %s fwd lane: got v=%b a=%h d=%h t=%h exp v=%b a=%h d=%h t=%h",
                 r, fwd_out_vld, fwd_out_addr, fwd_out_data, fwd_out_ttag, e.fv, e.fa, e.fd, e.ft);
      end
      n_vec++;
      if (rsp_out_vld !== e.rv ||
          (e.rv && {rsp_out_addr, rsp_out_data, rsp_out_stag, rsp_out_rtag} !== {e.ra, e.rd, e.rs, e.rr})) begin
        n_bad++;
        $display("FAIL %s reply lane: got v=%b a=%h d=%h s=%h r=%h exp v=%b a=%h d=%h s=%h r=%h",
                 r, rsp_out_vld, rsp_out_addr, rsp_out_data, rsp_out_stag, rsp_out_rtag,
                 e.rv, e.ra, e.rd, e.rs, e.rr);
      end
      n_vec++;
      if (bwd_out_vld !== e.bv || (e.bv && {bwd_out_addr, bwd_out_ttag} !== {e.ba, e.bt})) begin
        n_bad++;
        $display("FAIL %s bwd lane: got v=%b a=%h t=%h exp v=%b a=%h t=%h",
                 r, bwd_out_vld, bwd_out_addr, bwd_out_ttag, e.bv, e.ba, e.bt);
      end
    end
  end

  task automatic check_reset_idle();
    n_vec++;
    if ({fwd_out_vld, rsp_out_vld, bwd_out_vld} !== 3'b000) begin
      n_bad++;
      $display("FAIL R7 valids in reset: got %b exp 000", {fwd_out_vld, rsp_out_vld, bwd_out_vld});
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; fwd_in_vld = 1'b0; bwd_in_vld = 1'b0;
    repeat (2) @(negedge clk);
    check_reset_idle();
    model_clear();
    rst = 1'b0;
  endtask

  function automatic logic [AW-1:0] fa_n(int i);
    return 32'h0000_1000 + AW'(i * 4);
  endfunction

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check_reset_idle();                       // R7
    rst = 1'b0;

    ld(32'h40, 8'h01, "R7 empty after reset");
    st(32'h40, 32'hDEAD_BEEF, 8'h10, "R1 pass A");
    st(32'h44, 32'h1234_5678, 8'h11, "R1 pass B");
    idle();
    ld(32'h40, 8'h20, "R3 hit A");
    ld(32'h48, 8'h21, "R2 miss");
    ld(32'h44, 8'h22, "R3 hit B");
    st(32'h40, 32'hCAFE_0001, 8'h30, "R4 overwrite A");
    ld(32'h40, 8'h23, "R4 newest value");
    step(1'b1, 32'h80, 32'hAAAA_5555, 8'h40, 1'b1, 32'h80, 8'h41, "R6 bypass new addr");
    step(1'b1, 32'h44, 32'h0BAD_F00D, 8'h42, 1'b1, 32'h44, 8'h43, "R6 bypass cached addr");
    step(1'b1, 32'h90, 32'h7, 8'h44, 1'b1, 32'h94, 8'h45, "R2 miss beside store");
    for (int i = 0; i < 6; i++) ld(32'h40 + AW'(i * 4), TW'(i), "R2/R3 stream");

    // Fill and replacement.
    do_reset();
    for (int i = 0; i < N; i++) st(fa_n(i), 32'h100 + DW'(i), TW'(i), "R5 fill");
    st(fa_n(5), 32'h5555, 8'hA5, "R4 update when full");
    ld(fa_n(0), 8'h01, "R5 full: first still hits");
    ld(fa_n(5), 8'h02, "R4 updated value");
    st(fa_n(N), 32'h999, 8'hB0, "R5 33rd address");
    ld(fa_n(0), 8'h03, "R5 first evicted");
    ld(fa_n(1), 8'h04, "R5 second kept");
    ld(fa_n(N), 8'h05, "R5 33rd hits");
    st(fa_n(N + 1), 32'h998, 8'hB1, "R5 34th address");
    ld(fa_n(1), 8'h06, "R5 second evicted");
    ld(fa_n(2), 8'h07, "R5 third kept");
    ld(fa_n(N + 1), 8'h08, "R5 34th hits");
    for (int i = 0; i < 4; i++) idle();

    // Reset clears the cache.
    do_reset();
    ld(fa_n(2), 8'h09, "R7 miss after reset");
    idle();
    idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule